// File: doc/BRIEF.md
# Burst Address Sequencer with Strobes

This block produces the word address for a synchronous burst memory. At a rising clock edge it takes in an external address when one of two active-low address strobes is low. One strobe is on the processor side and the other is on the controller side. After that, an active-low advance input steps the two low address bits through a four-word burst. The upper bits stay where they were loaded. A static order input selects the stepping pattern. When it is low, the low bits count upward modulo four. When it is high, they follow an XOR-interleaved pattern.

Three chip enables decide whether a loaded cycle is selected. The block outputs the current word address, a flag that marks the cycle as selected, and a flag that marks a selected cycle as a write. The write flag is taken from an active-low write input at load time. The storage array, the data path and the output drivers sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low, and after it is released with no other stimulus, the address, the valid flag and the write flag are all zero.
- R2: A processor strobe (`ps_n` low) with `cs1_n` low loads `addr_in` into the address at that edge. The valid flag becomes the selection decode, and the write flag becomes valid AND NOT `we_n`.
- R3: A controller strobe (`cs_n` low) with `ps_n` high loads `addr_in` in the same way. If `cs1_n` is high at that edge, the cycle is deselected and both the valid flag and the write flag become 0.
- R4: A processor strobe with `cs1_n` high is blocked. The address, the valid flag and the write flag keep their values, whatever `cs_n` and `adv_n` do in that cycle.
- R5: A cycle is selected only when `cs1_n` is 0, `cs2` is 1 and `cs3_n` is 0. A load under any other enable combination leaves the valid flag at 0.
- R6: With `ilv_mode` = 0, each advance adds 1 modulo 4 to address bits [1:0]. A start of 2 gives 2,3,0,1.
- R7: With `ilv_mode` = 1, beat k of a burst has the low bits equal to the loaded low bits XOR k. A start of 1 gives 1,0,3,2, and a start of 2 gives 2,3,0,1.
- R8: An advance (`adv_n` low with both strobes high) never changes address bits above bit 1. It also does not change the valid flag or the write flag.
- R9: With both strobes high and `adv_n` high, all outputs hold their values.
- R10: When both strobes are low in the same cycle, the processor strobe decides the result. It loads if `cs1_n` is low. It blocks, with everything held, if `cs1_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | AW | External word address |
| ps_n | input | 1 | Processor-side address strobe, active low |
| cs_n | input | 1 | Controller-side address strobe, active low |
| cs1_n | input | 1 | First chip enable, active low |
| cs2 | input | 1 | Second chip enable, active high |
| cs3_n | input | 1 | Third chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 1 | Write qualifier captured at load, active low |
| ilv_mode | input | 1 | Static order select: 0 linear, 1 interleaved |
| word_addr | output | AW | Current word address |
| cyc_valid | output | 1 | Current cycle is selected |
| cyc_write | output | 1 | Selected cycle is a write |

## Verification
The assertions check a set of rules on every cycle:
- an idle cycle holds the outputs;
- a blocked processor strobe holds the outputs;
- an advance leaves the upper address bits and the flags alone;
- a linear advance adds one to the low bits;
- a load outside the selection decode gives no valid cycle;
- a controller deselect clears the valid flag;
- the write flag never stands without the valid flag.

The full interleaved sequence, the wrap of a burst after four beats, and the priority between the two strobes when both are low can only be shown by the bench's scenarios. The bench compares these against its behavioural model, which it reset-cycles through both order settings.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          ps_n,
  input  logic          cs_n,
  input  logic          cs1_n,
  input  logic          cs2,
  input  logic          cs3_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          ilv_mode,
  output logic [AW-1:0] word_addr,
  output logic          cyc_valid,
  output logic          cyc_write
);
  localparam int HW = AW - 2;

  logic [HW-1:0] hi_q;
  logic [1:0]    base_q;
  logic [1:0]    beat_q;
  logic          valid_q;
  logic          write_q;
  logic [1:0]    low;

  wire sel     = !cs1_n && cs2 && !cs3_n;
  wire p_load  = !ps_n && !cs1_n;
  wire p_block = !ps_n && cs1_n;
  wire c_load  = ps_n && !cs_n;
  wire load    = p_load || c_load;
  wire step    = ps_n && cs_n && !adv_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      base_q  <= '0;
      beat_q  <= '0;
      valid_q <= 1'b0;
      write_q <= 1'b0;
    end else if (load) begin
      hi_q    <= addr_in[AW-1:2];
      base_q  <= addr_in[1:0];
      beat_q  <= '0;
      valid_q <= sel;
      write_q <= sel && !we_n;
    end else if (step) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign low       = ilv_mode ? (base_q ^ beat_q) : (base_q + beat_q);
  assign word_addr = {hi_q, low};
  assign cyc_valid = valid_q;
  assign cyc_write = write_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_n && cs_n && adv_n) |=> ($stable(word_addr) && $stable(cyc_valid) && $stable(cyc_write))); // R9
  AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    p_block |=> ($stable(word_addr) && $stable(cyc_valid) && $stable(cyc_write))); // R4
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ($stable(word_addr[AW-1:2]) && $stable(cyc_valid) && $stable(cyc_write))); // R8
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ilv_mode) |=> (word_addr[1:0] == $past(word_addr[1:0]) + 2'd1)); // R6
  AST_UNSELECTED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !(!cs1_n && cs2 && !cs3_n)) |=> !cyc_valid); // R5
  AST_CTRL_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_n && !cs_n && cs1_n) |=> (!cyc_valid && !cyc_write)); // R3
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_write |-> cyc_valid); // R2
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          ps_n = 1'b1, cs_n = 1'b1, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic          adv_n = 1'b1, we_n = 1'b1, ilv_mode = 1'b0;
  logic [AW-1:0] word_addr;
  logic          cyc_valid, cyc_write;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_hi, m_start, m_beat, m_valid, m_write;

  always #4 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ps_n(ps_n), .cs_n(cs_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv_n(adv_n), .we_n(we_n),
    .ilv_mode(ilv_mode), .word_addr(word_addr), .cyc_valid(cyc_valid),
    .cyc_write(cyc_write)
  );

  function automatic int model_addr();
    int lo;
    if (ilv_mode) lo = m_start ^ m_beat;
    else lo = (m_start + m_beat) % 4;
    return m_hi * 4 + lo;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_start = 0; m_beat = 0; m_valid = 0; m_write = 0;
    end else if (ps_n == 1'b0) begin
      if (cs1_n == 1'b0) begin
        m_hi = int'(addr_in) / 4; m_start = int'(addr_in) % 4; m_beat = 0;
        m_valid = (cs2 == 1'b1 && cs3_n == 1'b0) ? 1 : 0;
        m_write = (m_valid == 1 && we_n == 1'b0) ? 1 : 0;
      end
    end else if (cs_n == 1'b0) begin
      m_hi = int'(addr_in) / 4; m_start = int'(addr_in) % 4; m_beat = 0;
      m_valid = (cs1_n == 1'b0 && cs2 == 1'b1 && cs3_n == 1'b0) ? 1 : 0;
      m_write = (m_valid == 1 && we_n == 1'b0) ? 1 : 0;
    end else if (adv_n == 1'b0) begin
      m_beat = (m_beat + 1) % 4;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, int'(word_addr), model_addr(), "word_addr");
      check(cur_req, int'(cyc_valid), m_valid, "cyc_valid");
      check(cur_req, int'(cyc_write), m_write, "cyc_write");
    end
  end

  task automatic go(input bit p, input bit c, input bit e1, input bit e2, input bit e3,
                    input bit adv, input bit wr, input logic [AW-1:0] a);
    ps_n = p; cs_n = c; cs1_n = e1; cs2 = e2; cs3_n = e3; adv_n = adv; we_n = wr; addr_in = a;
    @(negedge clk);
  endtask

  task automatic idle();
    go(1, 1, 1, 0, 1, 1, 1, '0);
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 1'b0; ilv_mode = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    do_reset(1'b0);
    idle();
    check("R1", int'(word_addr), 0, "reset addr");
    check("R1", int'(cyc_valid), 0, "reset valid");

    cur_req = "R6";
    go(0, 1, 0, 1, 0, 1, 1, 8'hA6);
    check("R2", int'(word_addr), 8'hA6, "load addr");
    check("R2", int'(cyc_valid), 1, "load valid");
    check("R2", int'(cyc_write), 0, "load read");
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R6", int'(word_addr), 8'hA7, "lin beat1");
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R6", int'(word_addr), 8'hA4, "lin beat2");
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R6", int'(word_addr), 8'hA5, "lin beat3");
    check("R8", int'(cyc_valid), 1, "valid kept over advance");
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R8", int'(word_addr), 8'hA6, "lin wrap");

    cur_req = "R9";
    go(1, 1, 0, 1, 0, 1, 0, 8'h11);
    check("R9", int'(word_addr), 8'hA6, "idle hold");

    cur_req = "R2";
    go(0, 1, 0, 1, 0, 1, 0, 8'h3C);
    check("R2", int'(cyc_write), 1, "write load");

    cur_req = "R4";
    go(0, 0, 1, 1, 0, 0, 1, 8'h55);
    check("R4", int'(word_addr), 8'h3C, "blocked hold addr");
    check("R4", int'(cyc_write), 1, "blocked hold write");

    cur_req = "R10";
    go(0, 0, 1, 1, 0, 1, 1, 8'h77);
    check("R10", int'(cyc_valid), 1, "both strobes cs1 high no deselect");
    go(0, 0, 0, 1, 0, 1, 1, 8'h48);
    check("R10", int'(word_addr), 8'h48, "both strobes load");

    cur_req = "R3";
    go(1, 0, 1, 1, 0, 1, 0, 8'h90);
    check("R3", int'(cyc_valid), 0, "ctrl deselect valid");
    check("R3", int'(cyc_write), 0, "ctrl deselect write");
    go(1, 0, 0, 1, 0, 1, 0, 8'h92);
    check("R3", int'(cyc_valid), 1, "ctrl select");
    check("R3", int'(cyc_write), 1, "ctrl write");

    cur_req = "R5";
    go(0, 1, 0, 0, 0, 1, 0, 8'h10); check("R5", int'(cyc_valid), 0, "cs2 low");
    go(0, 1, 0, 1, 1, 1, 0, 8'h10); check("R5", int'(cyc_valid), 0, "cs3_n high");
    go(1, 0, 0, 1, 0, 1, 1, 8'h10); check("R5", int'(cyc_valid), 1, "all enabled");

    for (int k = 0; k < 40; k++) begin
      cur_req = "R8";
      go(k % 3 == 0, k % 5 != 1, k % 7 == 2, k % 2 == 0, k % 4 == 3, k % 3 == 1, k % 2 == 1,
         AW'(k * 37));
    end

    cur_req = "R1";
    do_reset(1'b1);
    idle();
    cur_req = "R7";
    go(0, 1, 0, 1, 0, 1, 1, 8'h31);
    check("R7", int'(word_addr), 8'h31, "ilv beat0");
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R7", int'(word_addr), 8'h30, "ilv beat1");
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R7", int'(word_addr), 8'h33, "ilv beat2");
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R7", int'(word_addr), 8'h32, "ilv beat3");
    go(1, 0, 0, 1, 0, 1, 1, 8'hC2);
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R7", int'(word_addr), 8'hC3, "ilv s2 beat1");
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R7", int'(word_addr), 8'hC0, "ilv s2 beat2");
    go(1, 1, 1, 0, 1, 0, 1, '0); check("R7", int'(word_addr), 8'hC1, "ilv s2 beat3");
    for (int k = 0; k < 40; k++) begin
      go(k % 4 == 0, k % 3 != 2, k % 5 == 1, 1, k % 6 == 5, k % 2 == 0, k % 3 == 0,
         AW'(k * 53 + 7));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule